// File: doc/BRIEF.md
# Register-Controlled Shifter With Carry

This block shifts or rotates a data word by an amount that arrives at run time in a register operand, and produces the carry that the shift generates. Four kinds of operation are supported: logical left, logical right, arithmetic right and rotate right. Only the low byte of the amount operand counts, so the effective amount runs from 0 to 255. Amounts equal to or wider than the data word follow their own result and carry rules for each kind.

Alongside the result and the carry bit, the block raises a carry-update flag whenever the operation defines a new carry value. A zero effective amount leaves the data unchanged and drops the update flag, so the flag logic around the block keeps its previous carry. Rotate reduces the amount modulo the word width, but still distinguishes a true zero from a non-zero multiple of the width.

The datapath is combinational. A parameter can add one output register stage, which is on by default. The surrounding pipeline uses the block for variable-shift instructions that set flags.

Top module: `reg_shifter`

## Requirements
- R1: Only amount_i[7:0] sets the effective amount. Bits 31..8 of amount_i have no effect on any output.
- R2: The kind code 2'b00 selects logical left. For effective amounts 1..31 the result is value shifted left with zeros in, and the carry is value bit (32 - amount).
- R3: For logical left, an amount of exactly 32 gives result 0 with carry = value bit 0. Amounts 33..255 give result 0 and carry 0.
- R4: The kind code 2'b01 selects logical right. For amounts 1..31 the result is value shifted right with zeros in, and the carry is value bit (amount - 1).
- R5: For logical right, an amount of exactly 32 gives result 0 with carry = value bit 31. Amounts 33..255 give result 0 and carry 0.
- R6: The kind code 2'b10 selects arithmetic right. For amounts 1..31 the sign bit fills from the top and the carry is value bit (amount - 1). Amounts 32..255 give every result bit equal to value bit 31, and the carry is value bit 31.
- R7: The kind code 2'b11 selects rotate right by r = amount mod 32. When r is non-zero, the result is value rotated right by r and the carry is value bit (r - 1).
- R8: For rotate right, a non-zero amount that is a multiple of 32 (32, 64, ..., 224) returns value unchanged with carry = value bit 31.
- R9: For every kind, an effective amount of 0 returns value unchanged, with carry_upd_o = 0 and carry_o = 0.
- R10: For every kind, carry_upd_o = 1 whenever the effective amount is non-zero.
- R11: With the default output register, the outputs reflect the inputs of the previous rising clock edge. While rst is high, result_o, carry_o and carry_upd_o are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| kind_i | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| value_i | input | 32 | Data word to shift |
| amount_i | input | 32 | Amount operand; only bits 7..0 are used |
| result_o | output | 32 | Shifted or rotated word |
| carry_o | output | 1 | Carry produced by the operation, 0 when none is produced |
| carry_upd_o | output | 1 | High when carry_o holds a new carry value |

## Verification
The bench targets the boundaries where the rules change: amounts 31, 32 and 33, the top value 255, and rotate amounts of 32, 64 and 224 next to 33. A design that treats 32 like a larger amount loses the bit-0 or bit-31 carry. A design that reduces rotate amounts modulo 32 without checking the whole byte reports a multiple of 32 as a no-op with no carry update. Zero amounts are applied to every kind, and amount words with non-zero upper bits are applied as well. These catch a design that drives the update flag for a zero shift, or that decodes more than the low byte. Random operations on negative and positive words check sign filling and the carry bit position against a behavioural model on every cycle.

// File: rtl/rshift_pkg.sv
package rshift_pkg;

    // Operation codes presented on kind_i.
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    // Where the effective amount sits relative to the data width.
    typedef enum logic [1:0] {
        RNG_ZERO = 2'b00,   // amount == 0
        RNG_PART = 2'b01,   // 1 .. width-1
        RNG_FULL = 2'b10,   // amount == width
        RNG_OVER = 2'b11    // above width
    } amt_range_e;

    // Carry result of one operation.
    typedef struct packed {
        logic bit_val;
        logic valid;
    } carry_res_t;

    localparam carry_res_t CARRY_KEEP = '{bit_val: 1'b0, valid: 1'b0};

endpackage

// File: rtl/amount_classify.sv
module amount_classify
    import rshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] amount_raw,
    output amt_range_e        range_o,
    output logic [SH_W-1:0]   rem_o,
    output logic              rem_zero_o
);

    localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

    logic [AMT_W-1:0] amt;

    assign amt        = amount_raw[AMT_W-1:0];
    assign rem_o      = amt[SH_W-1:0];
    assign rem_zero_o = (amt[SH_W-1:0] == '0);

    always_comb begin
        if (amt == '0)
            range_o = RNG_ZERO;
        else if (amt < WIDTH_AMT)
            range_o = RNG_PART;
        else if (amt == WIDTH_AMT)
            range_o = RNG_FULL;
        else
            range_o = RNG_OVER;
    end

    // An in-range amount always leaves a non-zero remainder (R7, R2, R4, R6)
    always_comb begin
        if (range_o == RNG_PART)
            assert_part_rem_nonzero_R7: assert (!rem_zero_o);
    end

endmodule

// File: rtl/barrel_right.sv
module barrel_right #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   dist_i,
    input  logic              rotate_i,
    input  logic              fill_i,
    output logic [DATA_W-1:0] data_o
);

    logic [SH_W:0][DATA_W-1:0] stage;

    assign stage[0] = data_i;

    for (genvar g = 0; g < SH_W; g++) begin : gen_stage
        localparam int STEP = 1 << g;
        logic [DATA_W-1:0] moved;

        assign moved = rotate_i
                     ? {stage[g][STEP-1:0], stage[g][DATA_W-1:STEP]}
                     : {{STEP{fill_i}}, stage[g][DATA_W-1:STEP]};

        assign stage[g+1] = dist_i[g] ? moved : stage[g];
    end

    assign data_o = stage[SH_W];

endmodule

// File: rtl/carry_pick.sv
module carry_pick
    import rshift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  shift_kind_e       kind_i,
    input  amt_range_e        range_i,
    input  logic [SH_W-1:0]   rem_i,
    input  logic              rem_zero_i,
    input  logic [DATA_W-1:0] value_i,
    output carry_res_t        carry_o
);

    localparam logic [SH_W:0] WIDTH_IDX = (SH_W+1)'(DATA_W);

    logic [SH_W:0]   left_full;
    logic [SH_W-1:0] left_idx;
    logic [SH_W-1:0] right_idx;
    logic            msb;
    logic            left_bit;
    logic            right_bit;

    assign left_full = WIDTH_IDX - {1'b0, rem_i};
    assign left_idx  = left_full[SH_W-1:0];
    assign right_idx = rem_i - 1'b1;
    assign msb       = value_i[DATA_W-1];
    assign left_bit  = value_i[left_idx];
    assign right_bit = value_i[right_idx];

    always_comb begin
        carry_o = CARRY_KEEP;
        unique case (range_i)
            RNG_ZERO: carry_o = CARRY_KEEP;
            RNG_PART: begin
                carry_o.valid   = 1'b1;
                carry_o.bit_val = (kind_i == SK_LSL) ? left_bit : right_bit;
            end
            RNG_FULL: begin
                carry_o.valid   = 1'b1;
                carry_o.bit_val = (kind_i == SK_LSL) ? value_i[0] : msb;
            end
            RNG_OVER: begin
                carry_o.valid = 1'b1;
                unique case (kind_i)
                    SK_LSL, SK_LSR: carry_o.bit_val = 1'b0;
                    SK_ASR:         carry_o.bit_val = msb;
                    SK_ROR:         carry_o.bit_val = rem_zero_i ? msb : right_bit;
                    default:        carry_o.bit_val = 1'b0;
                endcase
            end
            default: carry_o = CARRY_KEEP;
        endcase
    end

endmodule

// File: rtl/reg_shifter.sv
module reg_shifter
    import rshift_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic [DATA_W-1:0] amount_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              carry_upd_o
);

    localparam int SH_W = $clog2(DATA_W);

    shift_kind_e       kind;
    amt_range_e        range;
    logic [SH_W-1:0]   rem;
    logic              rem_zero;
    logic [DATA_W-1:0] value_rev;
    logic [DATA_W-1:0] barrel_in;
    logic [DATA_W-1:0] barrel_out;
    logic [DATA_W-1:0] barrel_rev;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] result_c;
    logic              is_left;
    logic              sign;
    carry_res_t        carry_c;

    assign kind    = shift_kind_e'(kind_i);
    assign is_left = (kind == SK_LSL);
    assign sign    = value_i[DATA_W-1];

    amount_classify #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_classify (
        .amount_raw (amount_i),
        .range_o    (range),
        .rem_o      (rem),
        .rem_zero_o (rem_zero)
    );

    // Left shifts reuse the right-shift network on the bit-reversed word.
    for (genvar i = 0; i < DATA_W; i++) begin : gen_rev
        assign value_rev[i]  = value_i[DATA_W-1-i];
        assign barrel_rev[i] = barrel_out[DATA_W-1-i];
    end

    assign barrel_in = is_left ? value_rev : value_i;

    barrel_right #(.DATA_W(DATA_W)) u_barrel (
        .data_i   (barrel_in),
        .dist_i   (rem),
        .rotate_i (kind == SK_ROR),
        .fill_i   ((kind == SK_ASR) & sign),
        .data_o   (barrel_out)
    );

    assign shifted = is_left ? barrel_rev : barrel_out;

    always_comb begin
        result_c = value_i;
        if (kind == SK_ROR) begin
            result_c = shifted;
        end else begin
            unique case (range)
                RNG_ZERO: result_c = value_i;
                RNG_PART: result_c = shifted;
                RNG_FULL,
                RNG_OVER: result_c = (kind == SK_ASR) ? {DATA_W{sign}} : '0;
                default:  result_c = value_i;
            endcase
        end
    end

    carry_pick #(.DATA_W(DATA_W)) u_carry (
        .kind_i     (kind),
        .range_i    (range),
        .rem_i      (rem),
        .rem_zero_i (rem_zero),
        .value_i    (value_i),
        .carry_o    (carry_c)
    );

    if (OUT_REG) begin : gen_out_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                result_o    <= '0;
                carry_o     <= 1'b0;
                carry_upd_o <= 1'b0;
            end else begin
                result_o    <= result_c;
                carry_o     <= carry_c.bit_val;
                carry_upd_o <= carry_c.valid;
            end
        end

        // Zero amount: word passes through, carry is kept (R9)
        assert_zero_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (amount_i[AMT_W-1:0] == '0) |=>
                (!carry_upd_o && !carry_o && result_o == $past(value_i)));

        // Any non-zero amount produces a carry (R10)
        assert_nonzero_updates_R10: assert property (@(posedge clk) disable iff (rst)
            (amount_i[AMT_W-1:0] != '0) |=> carry_upd_o);

        // Arithmetic right at or beyond the width fills with the sign (R6)
        assert_asr_sign_fill_R6: assert property (@(posedge clk) disable iff (rst)
            (kind_i == 2'b10 && amount_i[AMT_W-1:0] >= AMT_W'(DATA_W)) |=>
                (result_o == {DATA_W{$past(value_i[DATA_W-1])}} &&
                 carry_o == $past(value_i[DATA_W-1])));

        // Logical left beyond the width clears word and carry (R3)
        assert_lsl_over_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (kind_i == 2'b00 && amount_i[AMT_W-1:0] > AMT_W'(DATA_W)) |=>
                (result_o == '0 && !carry_o));

        // Logical right beyond the width clears word and carry (R5)
        assert_lsr_over_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (kind_i == 2'b01 && amount_i[AMT_W-1:0] > AMT_W'(DATA_W)) |=>
                (result_o == '0 && !carry_o));

        // Rotate by a non-zero multiple of the width (R8)
        assert_ror_multiple_R8: assert property (@(posedge clk) disable iff (rst)
            (kind_i == 2'b11 && amount_i[AMT_W-1:0] != '0 &&
             amount_i[SH_W-1:0] == '0) |=>
                (result_o == $past(value_i) && carry_o == $past(value_i[DATA_W-1])));

        // Held outputs are cleared while reset is applied (R11)
        assert_reset_clear_R11: assert property (@(posedge clk)
            rst |=> (result_o == '0 && !carry_o && !carry_upd_o));
    end else begin : gen_out_comb
        assign result_o    = result_c;
        assign carry_o     = carry_c.bit_val;
        assign carry_upd_o = carry_c.valid;
    end

endmodule

// File: tb/tb_reg_shifter.sv
module tb_reg_shifter;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  kind_i = 2'b00;
    logic [31:0] value_i = '0;
    logic [31:0] amount_i = '0;
    logic [31:0] result_o;
    logic        carry_o;
    logic        carry_upd_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        c;
        logic        u;
        string       tag;
        int          kind;
        int          amt;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_shifter dut (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (kind_i),
        .value_i     (value_i),
        .amount_i    (amount_i),
        .result_o    (result_o),
        .carry_o     (carry_o),
        .carry_upd_o (carry_upd_o)
    );

    // Behavioural reference following the requirement text.
    function automatic exp_t model(int k, logic [31:0] v, logic [31:0] a);
        exp_t e;
        int n = int'(a[7:0]);
        int r = n % 32;
        e.kind = k; e.amt = n; e.u = 1'b1; e.c = 1'b0; e.res = v;
        if (n == 0) begin
            e.u = 1'b0; e.tag = "R9";
        end else begin
            case (k)
                0: begin
                    if (n < 32)       begin e.res = v << n; e.c = v[32-n]; e.tag = "R2"; end
                    else if (n == 32) begin e.res = '0; e.c = v[0]; e.tag = "R3"; end
                    else              begin e.res = '0; e.c = 1'b0; e.tag = "R3"; end
                end
                1: begin
                    if (n < 32)       begin e.res = v >> n; e.c = v[n-1]; e.tag = "R4"; end
                    else if (n == 32) begin e.res = '0; e.c = v[31]; e.tag = "R5"; end
                    else              begin e.res = '0; e.c = 1'b0; e.tag = "R5"; end
                end
                2: begin
                    e.tag = "R6";
                    if (n < 32) begin e.res = 32'($signed(v) >>> n); e.c = v[n-1]; end
                    else        begin e.res = {32{v[31]}}; e.c = v[31]; end
                end
                default: begin
                    if (r == 0) begin e.res = v; e.c = v[31]; e.tag = "R8"; end
                    else begin
                        e.res = (v >> r) | (v << (32 - r)); e.c = v[r-1]; e.tag = "R7";
                    end
                end
            endcase
        end
        return e;
    endfunction

    task automatic check_bit(string tag, string what, logic got, logic expv);
        tests++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, expv);
        end
    endtask

    task automatic check_word(string tag, string what, logic [31:0] got, logic [31:0] expv);
        tests++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, expv);
        end
    endtask

    // Drive at a falling edge, compare one cycle later (R11 latency).
    task automatic apply(int k, logic [31:0] v, logic [31:0] a, string tag_over);
        exp_t e;
        e = model(k, v, a);
        if (tag_over != "") e.tag = tag_over;
        kind_i = 2'(k); value_i = v; amount_i = a;
        exp_q.push_back(e);
        @(negedge clk);
        e = exp_q.pop_front();
        check_word(e.tag, $sformatf("result kind=%0d amt=%0d", e.kind, e.amt), result_o, e.res);
        check_bit(e.tag, $sformatf("carry kind=%0d amt=%0d", e.kind, e.amt), carry_o, e.c);
        check_bit(e.u ? "R10" : "R9", $sformatf("carry_upd kind=%0d amt=%0d", e.kind, e.amt),
                  carry_upd_o, e.u);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state, with non-zero inputs applied
        kind_i = 2'b11; value_i = 32'hDEAD_BEEF; amount_i = 32'd5;
        repeat (3) @(negedge clk);
        check_word("R11", "result in reset", result_o, '0);
        check_bit("R11", "carry in reset", carry_o, 1'b0);
        check_bit("R11", "carry_upd in reset", carry_upd_o, 1'b0);
        rst = 1'b0;

        // R2, R3: logical left around the width
        apply(0, 32'h8000_0001, 32'd1, "");
        apply(0, 32'h1234_5678, 32'd4, "");
        apply(0, 32'h0000_0003, 32'd31, "");
        apply(0, 32'h0000_0001, 32'd32, "R3");
        apply(0, 32'hFFFF_FFFF, 32'd33, "R3");
        apply(0, 32'hFFFF_FFFF, 32'd255, "R3");
        // R4, R5: logical right around the width
        apply(1, 32'h0000_0001, 32'd1, "");
        apply(1, 32'h8000_0000, 32'd31, "");
        apply(1, 32'h8000_0000, 32'd32, "R5");
        apply(1, 32'hFFFF_FFFF, 32'd40, "R5");
        // R6: arithmetic right on negative and positive words
        apply(2, 32'h8000_0010, 32'd4, "R6");
        apply(2, 32'h8000_0000, 32'd31, "R6");
        apply(2, 32'h8000_0000, 32'd32, "R6");
        apply(2, 32'hF000_0000, 32'd200, "R6");
        apply(2, 32'h7FFF_FFFF, 32'd32, "R6");
        // R7, R8: rotate by remainders and multiples of the width
        apply(3, 32'h0000_0001, 32'd1, "R7");
        apply(3, 32'h1234_5678, 32'd8, "R7");
        apply(3, 32'h1234_5678, 32'd33, "R7");
        apply(3, 32'h8765_4321, 32'd32, "R8");
        apply(3, 32'h0765_4321, 32'd64, "R8");
        apply(3, 32'hC000_0000, 32'd224, "R8");
        // R9: zero amount for every kind
        for (int k = 0; k < 4; k++) apply(k, 32'hA5A5_5A5A, 32'd0, "R9");
        // R1: upper amount bits ignored
        apply(0, 32'h0000_00FF, 32'h0000_0100, "R1");
        apply(3, 32'hF0F0_F0F0, 32'h0000_0100, "R1");
        apply(1, 32'hF000_000F, 32'hFFFF_FF05, "R1");
        apply(2, 32'h8000_0000, 32'h1234_5620, "R1");

        // Random mix compared against the model each cycle.
        for (int i = 0; i < 600; i++) begin
            logic [31:0] v = $urandom;
            logic [31:0] a = $urandom;
            if (i % 3 == 0) a[7:0] = 8'($urandom_range(0, 40));
            apply(int'($urandom_range(0, 3)), v, a, "");
        end

        // R11: back into reset clears the held outputs
        rst = 1'b1;
        @(negedge clk);
        check_word("R11", "result after reset", result_o, '0);
        check_bit("R11", "carry_upd after reset", carry_upd_o, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule